// File: doc/BRIEF.md
# Synchronous Transport Frame Byte Sequencer

This block walks through the byte positions of a 9-row by 270-column synchronous transport frame, one position per byte clock. At 8000 frames per second this gives a 155.52 Mbit/s line rate. Bytes go out row after row, and left to right within each row. The first nine columns of every row form a fixed overhead block. Rows 0 to 2 of that block hold regenerator section overhead, row 3 holds the administrative-unit pointer, and rows 4 to 8 hold multiplexer section overhead. The other 261 columns carry the floating payload area: one path-overhead column followed by a 260-column container.

For every position the block picks one of three byte sources and registers it onto the output bus. The sources are the section overhead input, the pointer input from a pointer processor, and the payload stream from a container source. It also outputs the position itself, a frame-start strobe, a payload-enable strobe and a region tag. It tells the payload source when a byte is taken through a ready signal. The position counters run freely after reset and do not depend on any input.

Top module: `stm1_frame_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs go to zero at that edge: byte 0, row 0, column 0, no frame start, no payload enable, tag 0. `pay_ready` is 0 during reset.
- R2: After reset is released, the position is row 0, column 0. The column advances by one at every clock and wraps from 269 to 0. The row advances when the column wraps and goes from 8 back to 0. A frame is therefore 2430 bytes.
- R3: `frame_start` is 1 for exactly one byte per frame, on the byte at row 0, column 0 (0-based).
- R4: The region tag uses these codes. Code 3 means payload and applies to columns 9 to 269. In columns 0 to 8, code 0 applies to rows 0 to 2, code 1 to row 3, and code 2 to rows 4 to 8.
- R5: The output byte for a position is the value of `soh_byte` for tags 0 and 2, of `ptr_byte` for tag 1, and of `pay_byte` for tag 3. The input is taken as it stands at the clock edge that registers that position.
- R6: `payload_en` is 1 exactly when the output column is 9 or higher. This gives 2349 payload bytes per frame.
- R7: `pay_ready` is 1 in the cycle in which the internal position is in the payload area. The payload byte is taken at the end of that cycle and appears on the outputs, with `payload_en`, one cycle later.
- R8: A reset asserted in the middle of a frame restarts the sequence at row 0, column 0 once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| soh_byte | input | 8 | Section overhead byte source |
| ptr_byte | input | 8 | Pointer byte source |
| pay_byte | input | 8 | Payload byte source |
| pay_ready | output | 1 | Payload byte is taken at this edge |
| tx_byte | output | 8 | Registered frame byte |
| row_o | output | 4 | Row of tx_byte, 0 to 8 |
| col_o | output | 9 | Column of tx_byte, 0 to 269 |
| frame_start | output | 1 | First byte of a frame |
| payload_en | output | 1 | tx_byte is a payload byte |
| region_o | output | 2 | Region tag of tx_byte |

## Verification
`pay_ready` is combinational from the position counters, so it is due in the same cycle as the position it describes. Every registered output for that position appears one clock later. The bench drives the three sources and checks `pay_ready` at a falling edge. It then waits for the next falling edge and compares the byte, position, strobes and tag for that same position. Sampling always at falling edges keeps every comparison clear of the active edge. The sweep covers two full frames and a mid-frame reset, and it counts the bytes, payload bytes and frame starts in each frame.

// File: rtl/stm1_seq_pkg.sv
package stm1_seq_pkg;
  typedef enum logic [1:0] {
    TAG_RSEC = 2'd0,
    TAG_PTR  = 2'd1,
    TAG_MSEC = 2'd2,
    TAG_PAY  = 2'd3
  } area_t;
endpackage

// File: rtl/stm1_pos_counter.sv
module stm1_pos_counter #(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int RW   = 4,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q
);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (col_q == COL_LAST) begin
      col_q <= '0;
      row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_q != COL_LAST) |=> (col_q == $past(col_q) + 1'b1)); // R2
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (col_q == COL_LAST) |=> (col_q == '0)); // R2
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (col_q == COL_LAST && row_q == ROW_LAST) |=> (row_q == '0)); // R2
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (col_q != COL_LAST) |=> $stable(row_q)); // R2
endmodule

// File: rtl/stm1_region_decode.sv
module stm1_region_decode
  import stm1_seq_pkg::*;
#(
  parameter int OH_COLS   = 9,
  parameter int RSEC_ROWS = 3,
  parameter int PTR_ROW   = 3,
  parameter int RW        = 4,
  parameter int CW        = 9
) (
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  output area_t         area,
  output logic          in_pay
);
  always_comb begin
    if (col >= CW'(OH_COLS))
      area = TAG_PAY;
    else if (row < RW'(RSEC_ROWS))
      area = TAG_RSEC;
    else if (row == RW'(PTR_ROW))
      area = TAG_PTR;
    else
      area = TAG_MSEC;
    in_pay = (area == TAG_PAY);
  end
endmodule

// File: rtl/stm1_out_stage.sv
module stm1_out_stage
  import stm1_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 4,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  area_t         area,
  input  logic [DW-1:0] soh_byte,
  input  logic [DW-1:0] ptr_byte,
  input  logic [DW-1:0] pay_byte,
  output logic [DW-1:0] tx_byte,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          frame_start,
  output logic          payload_en,
  output logic [1:0]    region_o
);
  logic [DW-1:0] sel_byte;

  always_comb begin
    unique case (area)
      TAG_PTR: sel_byte = ptr_byte;
      TAG_PAY: sel_byte = pay_byte;
      default: sel_byte = soh_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte     <= '0;
      row_o       <= '0;
      col_o       <= '0;
      frame_start <= 1'b0;
      payload_en  <= 1'b0;
      region_o    <= 2'd0;
    end else begin
      tx_byte     <= sel_byte;
      row_o       <= row;
      col_o       <= col;
      frame_start <= (row == '0) && (col == '0);
      payload_en  <= (area == TAG_PAY);
      region_o    <= area;
    end
  end
endmodule

// File: rtl/stm1_frame_seq.sv
module stm1_frame_seq
  import stm1_seq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ROWS      = 9,
  parameter int COLS      = 270,
  parameter int OH_COLS   = 9,
  parameter int RSEC_ROWS = 3,
  parameter int PTR_ROW   = 3,
  localparam int RW       = $clog2(ROWS),
  localparam int CW       = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] soh_byte,
  input  logic [DW-1:0] ptr_byte,
  input  logic [DW-1:0] pay_byte,
  output logic          pay_ready,
  output logic [DW-1:0] tx_byte,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          frame_start,
  output logic          payload_en,
  output logic [1:0]    region_o
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  area_t         area;
  logic          in_pay;

  stm1_pos_counter #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .row_q(row_q), .col_q(col_q)
  );

  stm1_region_decode #(.OH_COLS(OH_COLS), .RSEC_ROWS(RSEC_ROWS), .PTR_ROW(PTR_ROW),
                       .RW(RW), .CW(CW)) u_dec (
    .row(row_q), .col(col_q), .area(area), .in_pay(in_pay)
  );

  stm1_out_stage #(.DW(DW), .RW(RW), .CW(CW)) u_out (
    .clk(clk), .rst(rst), .row(row_q), .col(col_q), .area(area),
    .soh_byte(soh_byte), .ptr_byte(ptr_byte), .pay_byte(pay_byte),
    .tx_byte(tx_byte), .row_o(row_o), .col_o(col_o), .frame_start(frame_start),
    .payload_en(payload_en), .region_o(region_o)
  );

  assign pay_ready = in_pay && !rst;

  AST_FS_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_o == '0 && col_o == '0)); // R3
  AST_PEN_TAG: assert property (@(posedge clk) disable iff (rst)
    payload_en |-> (region_o == 2'd3)); // R6
  AST_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
    pay_ready |=> payload_en); // R7
  AST_PAY_BYTE: assert property (@(posedge clk) disable iff (rst)
    payload_en |-> (tx_byte == $past(pay_byte))); // R5
  AST_PTR_BYTE: assert property (@(posedge clk) disable iff (rst)
    (region_o == 2'd1) |-> (tx_byte == $past(ptr_byte))); // R5
  AST_PTR_PLACE: assert property (@(posedge clk) disable iff (rst)
    (region_o == 2'd1) |-> (row_o == RW'(PTR_ROW) && col_o < CW'(OH_COLS))); // R4
endmodule

// File: tb/sim_stm1_frame_seq.sv
module sim_stm1_frame_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] soh_byte = '0, ptr_byte = '0, pay_byte = '0;
  logic       pay_ready;
  logic [7:0] tx_byte;
  logic [3:0] row_o;
  logic [8:0] col_o;
  logic       frame_start, payload_en;
  logic [1:0] region_o;

  int checks = 0;
  int failures = 0;
  int pay_cnt = 0;
  int fs_cnt = 0;

  always #5 clk = ~clk;

  stm1_frame_seq u0 (
    .clk(clk), .rst(rst), .soh_byte(soh_byte), .ptr_byte(ptr_byte), .pay_byte(pay_byte),
    .pay_ready(pay_ready), .tx_byte(tx_byte), .row_o(row_o), .col_o(col_o),
    .frame_start(frame_start), .payload_en(payload_en), .region_o(region_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_checks();
    chk("R1 tx_byte", tx_byte, 0);
    chk("R1 row", row_o, 0);
    chk("R1 col", col_o, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 payload_en", payload_en, 0);
    chk("R1 region", region_o, 0);
    chk("R1 pay_ready", pay_ready, 0);
  endtask

  // one byte position: drive sources, check ready, then check registered outputs
  task automatic step_pos(input int p);
    int q, r, c, tag, eb;
    q = p % 2430;
    r = q / 270;
    c = q % 270;
    if (c >= 9) tag = 3;
    else if (r < 3) tag = 0;
    else if (r == 3) tag = 1;
    else tag = 2;
    soh_byte = 8'((q * 7 + 1) & 255);
    ptr_byte = 8'((q * 13 + 100) & 255);
    pay_byte = 8'((q * 29 + 200) & 255);
    eb = (tag == 3) ? int'(pay_byte) : (tag == 1) ? int'(ptr_byte) : int'(soh_byte);
    chk("R7 pay_ready", pay_ready, (tag == 3) ? 1 : 0);
    @(negedge clk);
    chk("R2 row", row_o, r);
    chk("R2 col", col_o, c);
    chk("R3 frame_start", frame_start, (q == 0) ? 1 : 0);
    chk("R4 region", region_o, tag);
    chk("R6 payload_en", payload_en, (c >= 9) ? 1 : 0);
    chk("R5 tx_byte", tx_byte, eb);
    if (payload_en) pay_cnt++;
    if (frame_start) fs_cnt++;
    if (q == 2429) begin
      chk("R6 payload bytes per frame", pay_cnt, 2349);
      chk("R3 frame starts per frame", fs_cnt, 1);
      pay_cnt = 0;
      fs_cnt = 0;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    rst = 1'b0;
    for (int p = 0; p < 2 * 2430; p++) step_pos(p);
    for (int p = 0; p < 700; p++) step_pos(p);
    // R8: reset in mid-frame, then restart from position 0
    rst = 1'b1;
    @(negedge clk);
    reset_checks();
    rst = 1'b0;
    pay_cnt = 0;
    fs_cnt = 0;
    for (int p = 0; p < 2430 + 20; p++) step_pos(p);
    chk("R8 restart frame_start seen", fs_cnt, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule